// File: doc/BRIEF.md
# Repeating serial pattern generator

This block drives two independent serial outputs, each made of a pattern clock and a data line. Software loads a channel with a 64-bit pattern, a bit count, a repeat count and a clock divider, then sets that channel's enable bit. The channel sends the low pattern bits starting from bit 0, replays that sequence the requested number of times, and then raises its own completion interrupt. Turning a channel's enable off partway through drops the rest of the sequence and leaves the interrupt alone.

Configuration and status go through a plain word-addressed register port. A write takes effect at the clock edge where `reg_wr_i` is high. Reads are combinational from `reg_addr_i`. The serial outputs have no back-pressure: once a channel is running, its clock and data move on a fixed schedule and the receiver has to keep up. Every programmed count is one less than the count that takes effect. The block captures a channel's pattern, bit count, repeat count and divider when the channel starts, so later register writes only affect the next run.

Register map (word address: contents): 0 control (enable of channel c at bit c, polarity of channel c at bit 2+c); 1 and 2 divider of channel 0 and 1 (16 bits); 3 and 4 channel 0 pattern bits 31:0 and 63:32; 5 and 6 channel 1 pattern bits 31:0 and 63:32; 7 size (channel c: bit-count field at bits 16c+5:16c, repeat field at bits 16c+15:16c+6); 8 interrupt state (bit c = channel c done; write 1 to clear); 9 interrupt enable; 10 interrupt test (write 1 to set the state bit, reads as 0).

Top module: `serpat_gen`

## Requirements
- R1: After reset both pattern clocks and both data lines are 0, both interrupts are 0, and the control and interrupt state registers read 0.
- R2: Within one repetition a channel sends pattern bits in ascending order, bit 0 through bit L, where L is its bit-count field (0..63). That gives L+1 bits, and each bit is valid on the active edge of the pattern clock.
- R3: A channel sends exactly R+1 repetitions, where R is its repeat field, and then stops with no further active clock edges.
- R4: While a channel runs, its pattern clock changes level once every D+1 system clock cycles, where D is its divider.
- R5: With polarity 0 the pattern clock idles low, data changes on the falling edge and is valid on the rising edge. With polarity 1 the clock idles high and the edges swap roles. Data is 0 whenever the channel is not running.
- R6: When a channel finishes all repetitions, its interrupt state bit is set. Each interrupt output equals its state bit ANDed with its enable bit.
- R7: Clearing a channel's enable bit while it runs stops the channel at once. Data returns to 0, the clock returns to its idle level, and the done bit is not set.
- R8: A channel starts only on a 0-to-1 change of its enable bit. Rewriting enable as 1 after completion does not start a new run.
- R9: Writing 1 to an interrupt state bit clears it. Writing 1 to an interrupt test bit sets the matching state bit, and a set in the same cycle wins over a clear.
- R10: The divider, pattern words and size register read back the values last written.
- R11: The two channels run independently and can run at the same time with different settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| pclk_o | output | 2 | Pattern clock, one bit per channel |
| pdata_o | output | 2 | Pattern data, one bit per channel |
| irq_o | output | 2 | Done interrupt, one bit per channel |

## Verification
The first run uses a five-bit pattern repeated three times with divider 1 and polarity 0. This separates an off-by-one in the bit count from one in the repeat count, because every bit position is compared in order. A second run starts both channels together. One channel sends a single bit repeated four times with divider 2. The other sends all 64 bits once with divider 0 and polarity 1. Together they cover both ends of the bit-count range, the fastest clock and the inverted edge roles, and a channel that reads the other channel's settings would fail. A long run that is cut short shows an abort does not reach the done bit, and rewriting enable after completion shows that a level alone does not restart a channel.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int NCH     = 2;
  localparam int PAT_W   = 64;
  localparam int WORD_W  = 32;
  localparam int LEN_W   = $clog2(PAT_W);
  localparam int REP_W   = 10;
  localparam int FIELD_W = LEN_W + REP_W;
  localparam int DIV_W   = 16;
  localparam int ADDR_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 4'd0,
    A_DIV0   = 4'd1,
    A_DIV1   = 4'd2,
    A_PAT0L  = 4'd3,
    A_PAT0H  = 4'd4,
    A_PAT1L  = 4'd5,
    A_PAT1H  = 4'd6,
    A_SIZE   = 4'd7,
    A_ISTATE = 4'd8,
    A_IEN    = 4'd9,
    A_ITEST  = 4'd10
  } reg_addr_e;
endpackage

// File: rtl/pg_regs.sv
module pg_regs
  import pg_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [WORD_W-1:0]                wdata_i,
  input  logic [NCH-1:0]                   istate_i,
  output logic [WORD_W-1:0]                rdata_o,
  output logic [NCH-1:0]                   en_o,
  output logic [NCH-1:0]                   pol_o,
  output logic [NCH-1:0][DIV_W-1:0]        div_o,
  output logic [NCH-1:0][LEN_W-1:0]        len_o,
  output logic [NCH-1:0][REP_W-1:0]        reps_o,
  output logic [NCH-1:0][PAT_W-1:0]        pat_o,
  output logic [NCH-1:0]                   ien_o,
  output logic [NCH-1:0]                   clr_o,
  output logic [NCH-1:0]                   test_o
);
  localparam int HALF_W = PAT_W / 2;

  logic [NCH-1:0] en_q, pol_q, ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      pol_q <= '0;
      ien_q <= '0;
    end else if (wr_i) begin
      if (addr_i == A_CTRL) begin
        en_q  <= wdata_i[NCH-1:0];
        pol_q <= wdata_i[2*NCH-1:NCH];
      end
      if (addr_i == A_IEN) ien_q <= wdata_i[NCH-1:0];
    end
  end

  assign en_o  = en_q;
  assign pol_o = pol_q;
  assign ien_o = ien_q;
  assign clr_o  = (wr_i && addr_i == A_ISTATE) ? wdata_i[NCH-1:0] : '0;
  assign test_o = (wr_i && addr_i == A_ITEST)  ? wdata_i[NCH-1:0] : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] ADIV = ADDR_W'(int'(A_DIV0) + c);
    localparam logic [ADDR_W-1:0] APLO = ADDR_W'(int'(A_PAT0L) + 2*c);
    localparam logic [ADDR_W-1:0] APHI = ADDR_W'(int'(A_PAT0L) + 2*c + 1);
    logic [DIV_W-1:0] div_q;
    logic [PAT_W-1:0] pat_q;
    logic [LEN_W-1:0] len_q;
    logic [REP_W-1:0] reps_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        div_q  <= '0;
        pat_q  <= '0;
        len_q  <= '0;
        reps_q <= '0;
      end else if (wr_i) begin
        if (addr_i == ADIV) div_q <= wdata_i[DIV_W-1:0];
        if (addr_i == APLO) pat_q[HALF_W-1:0] <= wdata_i[HALF_W-1:0];
        if (addr_i == APHI) pat_q[PAT_W-1:HALF_W] <= wdata_i[HALF_W-1:0];
        if (addr_i == A_SIZE) begin
          len_q  <= wdata_i[c*FIELD_W +: LEN_W];
          reps_q <= wdata_i[c*FIELD_W+LEN_W +: REP_W];
        end
      end
    end

    assign div_o[c]  = div_q;
    assign pat_o[c]  = pat_q;
    assign len_o[c]  = len_q;
    assign reps_o[c] = reps_q;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:   rdata_o = WORD_W'({pol_q, en_q});
      A_ISTATE: rdata_o = WORD_W'(istate_i);
      A_IEN:    rdata_o = WORD_W'(ien_q);
      A_SIZE: begin
        for (int c = 0; c < NCH; c++)
          rdata_o[c*FIELD_W +: FIELD_W] = {reps_o[c], len_o[c]};
      end
      default: ;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == ADDR_W'(int'(A_DIV0) + c))
        rdata_o = WORD_W'(div_o[c]);
      if (addr_i == ADDR_W'(int'(A_PAT0L) + 2*c))
        rdata_o = WORD_W'(pat_o[c][HALF_W-1:0]);
      if (addr_i == ADDR_W'(int'(A_PAT0L) + 2*c + 1))
        rdata_o = WORD_W'(pat_o[c][PAT_W-1:HALF_W]);
    end
  end
endmodule

// File: rtl/pg_irq.sv
module pg_irq
  import pg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] done_i,
  input  logic [NCH-1:0] test_i,
  input  logic [NCH-1:0] clr_i,
  input  logic [NCH-1:0] en_i,
  output logic [NCH-1:0] state_o,
  output logic [NCH-1:0] irq_o
);
  logic [NCH-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= (state_q & ~clr_i) | done_i | test_i;
  end

  assign state_o = state_q;
  assign irq_o   = state_q & en_i;

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[c] && !done_i[c] && !test_i[c] |=> !state_o[c]);
    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[c] || test_i[c] |=> state_o[c]);
  end
endmodule

// File: rtl/pg_chan.sv
module pg_chan
  import pg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pol_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [REP_W-1:0] reps_i,
  input  logic [PAT_W-1:0] pat_i,
  output logic             pclk_o,
  output logic             data_o,
  output logic             done_o
);
  logic             en_q, active_q, phase_q, done_q;
  logic [DIV_W-1:0] div_cnt_q, div_q;
  logic [LEN_W-1:0] bit_q, len_q;
  logic [REP_W-1:0] rep_q, reps_q;
  logic [PAT_W-1:0] pat_q;
  logic             start;

  assign start = en_i && !en_q && !active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      active_q  <= 1'b0;
      phase_q   <= 1'b0;
      done_q    <= 1'b0;
      div_cnt_q <= '0;
      div_q     <= '0;
      bit_q     <= '0;
      len_q     <= '0;
      rep_q     <= '0;
      reps_q    <= '0;
      pat_q     <= '0;
    end else begin
      en_q   <= en_i;
      done_q <= 1'b0;
      if (!active_q) begin
        phase_q   <= 1'b0;
        div_cnt_q <= '0;
        if (start) begin
          active_q <= 1'b1;
          bit_q    <= '0;
          rep_q    <= '0;
          div_q    <= div_i;
          len_q    <= len_i;
          reps_q   <= reps_i;
          pat_q    <= pat_i;
        end
      end else if (!en_i) begin
        active_q <= 1'b0;
        phase_q  <= 1'b0;
      end else if (div_cnt_q == div_q) begin
        div_cnt_q <= '0;
        phase_q   <= !phase_q;
        if (phase_q) begin
          if (bit_q == len_q) begin
            bit_q <= '0;
            if (rep_q == reps_q) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end else begin
              rep_q <= rep_q + 1'b1;
            end
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end else begin
        div_cnt_q <= div_cnt_q + 1'b1;
      end
    end
  end

  assign pclk_o = phase_q ^ pol_i;
  assign data_o = active_q && pat_q[bit_q];
  assign done_o = done_q;

  assert_abort_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !en_i |=> !active_q && !done_o);
  assert_done_ends_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !active_q && $past(active_q));
  assert_div_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> div_cnt_q <= div_q);
  assert_idle_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !phase_q);
  assert_no_level_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q && en_q && en_i |=> !active_q);
endmodule

// File: rtl/serpat_gen.sv
module serpat_gen
  import pg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic [NCH-1:0]    pclk_o,
  output logic [NCH-1:0]    pdata_o,
  output logic [NCH-1:0]    irq_o
);
  logic [NCH-1:0]            en, pol, ien, clr, test, done, state;
  logic [NCH-1:0][DIV_W-1:0] div;
  logic [NCH-1:0][LEN_W-1:0] len;
  logic [NCH-1:0][REP_W-1:0] reps;
  logic [NCH-1:0][PAT_W-1:0] pat;

  pg_regs u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .istate_i(state), .rdata_o(reg_rdata_o),
    .en_o(en), .pol_o(pol), .div_o(div), .len_o(len), .reps_o(reps),
    .pat_o(pat), .ien_o(ien), .clr_o(clr), .test_o(test)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pg_chan u_chan (
      .clk_i, .rst_ni,
      .en_i(en[c]), .pol_i(pol[c]), .div_i(div[c]), .len_i(len[c]),
      .reps_i(reps[c]), .pat_i(pat[c]),
      .pclk_o(pclk_o[c]), .data_o(pdata_o[c]), .done_o(done[c])
    );
  end

  pg_irq u_irq (
    .clk_i, .rst_ni,
    .done_i(done), .test_i(test), .clr_i(clr), .en_i(ien),
    .state_o(state), .irq_o(irq_o)
  );
endmodule

// File: tb/test_serpat_gen.sv
module test_serpat_gen;
  import pg_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [WORD_W-1:0] wdata = '0;
  logic [WORD_W-1:0] rdata;
  logic [NCH-1:0]    pclk, pdata, irq;

  serpat_gen i_serpat_gen (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pclk_o(pclk), .pdata_o(pdata), .irq_o(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit q0[$];
  bit q1[$];
  bit armed[2];
  bit pol_exp[2];
  int div_exp[2];
  int last_edge[2];
  bit have_edge[2];
  bit prev_pclk[2];
  int cyc = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input reg_addr_e a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input reg_addr_e a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // driver side of the scoreboard
  task automatic push_exp(input int c, input logic [63:0] pat, input int len, input int reps);
    for (int r = 0; r <= reps; r++)
      for (int l = 0; l <= len; l++)
        if (c == 0) q0.push_back(pat[l]); else q1.push_back(pat[l]);
  endtask

  task automatic arm(input int c, input bit pol, input int dv);
    pol_exp[c] = pol; div_exp[c] = dv; have_edge[c] = 1'b0; armed[c] = 1'b1;
  endtask

  task automatic wait_irq(input int c, input string req);
    int t = 0;
    while (!irq[c] && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(irq[c] == 1'b1, req, irq[c], 1);
  endtask

  // monitor side: pop on each valid edge of an armed channel
  always @(negedge clk) begin
    cyc++;
    for (int c = 0; c < 2; c++) begin
      if (pclk[c] != prev_pclk[c] && armed[c]) begin
        if (have_edge[c])
          check(cyc - last_edge[c] == div_exp[c] + 1, "R4 half period", cyc - last_edge[c], div_exp[c] + 1);
        last_edge[c] = cyc;
        have_edge[c] = 1'b1;
        if ((pclk[c] ^ pol_exp[c]) == 1'b1) begin
          if ((c == 0 ? q0.size() : q1.size()) == 0) begin
            check(1'b0, "R3 extra bit", 1, 0);
          end else begin
            bit e;
            e = (c == 0) ? q0.pop_front() : q1.pop_front();
            check(pdata[c] == e, "R2 bit value", pdata[c], e);
          end
        end
      end
      prev_pclk[c] = pclk[c];
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pclk == 0 && pdata == 0, "R1 outputs", {pclk, pdata}, 0);
    check(irq == 0, "R1 irq", irq, 0);
    rd_reg(A_CTRL, d);   check(d == 0, "R1 ctrl", d, 0);
    rd_reg(A_ISTATE, d); check(d == 0, "R1 state", d, 0);

    // R10 readback
    wr_reg(A_PAT0L, 32'hA5C3_0F96);
    wr_reg(A_PAT0H, 32'h1234_5678);
    wr_reg(A_SIZE, 32'd4 | (32'd2 << 6) | (32'd63 << 16));
    wr_reg(A_DIV0, 32'd1);
    wr_reg(A_IEN, 32'd3);
    rd_reg(A_PAT0L, d); check(d == 32'hA5C3_0F96, "R10 pat lo", d, 32'hA5C3_0F96);
    rd_reg(A_PAT0H, d); check(d == 32'h1234_5678, "R10 pat hi", d, 32'h1234_5678);
    rd_reg(A_SIZE, d);  check(d == (32'd4 | (32'd2 << 6) | (32'd63 << 16)), "R10 size", d, 32'h3f0084);
    rd_reg(A_DIV0, d);  check(d == 1, "R10 div", d, 1);

    // run 1: ch0, 5 bits x 3 reps, div 1, polarity 0
    push_exp(0, 64'h1234_5678_A5C3_0F96, 4, 2);
    arm(0, 1'b0, 1);
    wr_reg(A_CTRL, 32'h1);
    wait_irq(0, "R6 done irq");
    check(q0.size() == 0, "R3 all reps sent", q0.size(), 0);
    armed[0] = 1'b0;
    rd_reg(A_ISTATE, d); check(d == 1, "R6 state", d, 1);
    check(pclk[0] == 0 && pdata[0] == 0, "R5 idle pol0", {pclk[0], pdata[0]}, 0);

    // R9 clear, then R8 no restart on a level
    wr_reg(A_ISTATE, 32'h1);
    check(irq[0] == 0, "R9 w1c", irq[0], 0);
    wr_reg(A_CTRL, 32'h1);
    repeat (120) @(negedge clk);
    check(irq[0] == 0 && pdata[0] == 0, "R8 no restart", {irq[0], pdata[0]}, 0);

    // R9 test bit, R6 gating
    wr_reg(A_IEN, 32'h1);
    wr_reg(A_ITEST, 32'h2);
    rd_reg(A_ISTATE, d); check(d == 2, "R9 test sets", d, 2);
    check(irq[1] == 0, "R6 gated", irq[1], 0);
    wr_reg(A_IEN, 32'h3);
    check(irq[1] == 1, "R6 enabled", irq[1], 1);
    wr_reg(A_ISTATE, 32'h2);
    check(irq == 0, "R9 clear", irq, 0);

    // run 2: both channels together
    wr_reg(A_CTRL, 32'h0);
    wr_reg(A_CTRL, 32'h8);
    check(pclk[1] == 1 && pdata[1] == 0, "R5 idle pol1", {pclk[1], pdata[1]}, 2);
    wr_reg(A_PAT1L, 32'hDEAD_BEEF);
    wr_reg(A_PAT1H, 32'h0F1E_2D3C);
    wr_reg(A_DIV1, 32'd0);
    wr_reg(A_DIV0, 32'd2);
    wr_reg(A_SIZE, 32'd0 | (32'd3 << 6) | (32'd63 << 16));
    push_exp(0, 64'h1234_5678_A5C3_0F96, 0, 3);
    push_exp(1, 64'h0F1E_2D3C_DEAD_BEEF, 63, 0);
    arm(0, 1'b0, 2);
    arm(1, 1'b1, 0);
    wr_reg(A_CTRL, 32'hB);
    wait_irq(0, "R11 ch0 done");
    wait_irq(1, "R11 ch1 done");
    check(q0.size() == 0 && q1.size() == 0, "R11 both complete", q0.size() + q1.size(), 0);
    armed[0] = 1'b0; armed[1] = 1'b0;
    rd_reg(A_ISTATE, d); check(d == 3, "R11 state", d, 3);
    check(pclk[1] == 1 && pdata[1] == 0, "R5 idle after pol1 run", {pclk[1], pdata[1]}, 2);

    // R7 abort
    wr_reg(A_ISTATE, 32'h3);
    wr_reg(A_CTRL, 32'h8);
    wr_reg(A_DIV0, 32'd3);
    wr_reg(A_SIZE, 32'd63 | (32'd5 << 6));
    push_exp(0, 64'h1234_5678_A5C3_0F96, 63, 5);
    arm(0, 1'b0, 3);
    wr_reg(A_CTRL, 32'h9);
    repeat (100) @(negedge clk);
    armed[0] = 1'b0;
    wr_reg(A_CTRL, 32'h8);
    repeat (2) @(negedge clk);
    check(pdata[0] == 0 && pclk[0] == 0, "R7 stopped", {pclk[0], pdata[0]}, 0);
    repeat (300) @(negedge clk);
    rd_reg(A_ISTATE, d); check(d == 0, "R7 no done", d, 0);
    check(irq[0] == 0, "R7 no irq", irq[0], 0);
    q0.delete();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule